// File: doc/BRIEF.md
# Serial EPROM Read-Memory Responder

This block is the device-side command engine of a single-wire serial EPROM. It starts after the bus-level addressing phase. A front end has already decoded the line waveform into single-cycle events: a bus reset, a host-written bit, and a host read-slot request. The engine returns one bit for each read slot, on `rd_bit`. The host first writes the read-memory opcode F0h and a 16-bit start address. It then reads back a checksum over those three bytes. After that it reads memory bytes from the start address up to the last byte of the 128-byte array. Once the array end is reached, a checksum over just the bytes that were read is offered. After that checksum the line reads as 1 until the next bus reset.

Both checksums use the 8-bit polynomial x^8+x^5+x^4+1. Bits are processed LSB first through a register that is cleared to zero. The data checksum register is cleared at the start of the first data byte. The storage array can be preloaded through a simple write port. Bytes that are never loaded read as FFh.

Top module: `eprom_read_engine`

## Requirements
- R1: After `rst_n` deasserts, every byte of the array reads FFh. A byte written through `load_en`/`load_addr`/`load_data` reads back as the loaded value.
- R2: The engine collects three bytes from host bits, each LSB first: the opcode F0h, then the low address byte, then the high address byte. A read slot during this collection returns 1 and does not disturb it.
- R3: The eight read slots after the high address byte return the checksum over the opcode and both address bytes, LSB first.
- R4: Next, read slots return array bytes LSB first. They start at the byte selected by the low 7 address bits and advance by one byte after every eight slots, through byte 127.
- R5: After byte 127, the next eight slots return the checksum over the data bytes read, LSB first. This checksum is computed in a register cleared when the first data byte starts.
- R6: After the data checksum, every read slot returns 1 until a bus reset.
- R7: A bus reset at any point returns the engine to opcode collection with no partial bits kept. A read aborted before byte 127 never yields a data checksum.
- R8: An opcode other than F0h makes every later read slot return 1 until a bus reset, whatever bits are written.
- R9: A 16-bit start address of 128 or more skips the data bytes. The header checksum is followed by eight 0 bits (the checksum of no bytes) and then by 1s.
- R10: Host-written bits that arrive during the checksum or data phases are ignored.
- R11: A bus reset takes priority over a write bit or read slot in the same cycle. That event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also erases the array to FFh |
| load_en | input | 1 | Preload strobe for the array |
| load_addr | input | 7 | Preload byte index |
| load_data | input | 8 | Preload byte value |
| bus_rst | input | 1 | One-cycle decoded bus reset pulse |
| wr_valid | input | 1 | One-cycle strobe: host wrote a bit |
| wr_bit | input | 1 | Value of the host-written bit |
| rd_req | input | 1 | One-cycle strobe: host read slot; `rd_bit` is consumed in this cycle |
| rd_bit | output | 1 | Bit presented for the current or next read slot |

## Verification
The assertions assume the bus decoder never raises `wr_valid` and `rd_req` in the same cycle. One bit event happens per slot, so the two strobes are exclusive. The assertions also assume each strobe lasts a single cycle. The bench drives every event from one task that raises exactly one strobe for one cycle and then idles for one cycle. The only deliberate overlap is a bus reset together with a write bit, which checks the priority rule. Random start addresses and array contents come from a fixed seed. A bench model computes every expected data and checksum bit.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_CMD      = 3'd0,
        ST_ADDR_LO  = 3'd1,
        ST_ADDR_HI  = 3'd2,
        ST_HDR_CRC  = 3'd3,
        ST_DATA     = 3'd4,
        ST_DATA_CRC = 3'd5,
        ST_DONE     = 3'd6,
        ST_IDLE     = 3'd7
    } rd_state_e;

    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

endpackage

// File: rtl/eprom_bitcrc.sv
module eprom_bitcrc #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    logic fb;

    always_comb begin
        fb      = crc_in[0] ^ bit_in;
        crc_out = crc_in >> 1;
        if (fb) begin
            crc_out = crc_out ^ POLY;
        end
    end
endmodule

// File: rtl/eprom_store.sv
module eprom_store #(
    parameter int DEPTH = 128,
    parameter int BW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [BW-1:0] load_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [SW-1:0] rd_sel,
    output logic          rd_out
);
    logic [BW-1:0] mem_q [DEPTH];
    logic [BW-1:0] mem_d [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
        always_comb begin
            mem_d[gi] = mem_q[gi];
            if (load_en && (load_addr == AW'(gi))) begin
                mem_d[gi] = load_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '1;
            end else begin
                mem_q[gi] <= mem_d[gi];
            end
        end
    end

    assign rd_out = mem_q[rd_addr][rd_sel];
endmodule

// File: rtl/eprom_read_engine.sv
module eprom_read_engine
    import eprom_rd_pkg::*;
#(
    parameter int         DEPTH    = 128,
    parameter logic [7:0] CMD_READ = 8'hF0,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [7:0]    load_data,
    input  logic          bus_rst,
    input  logic          wr_valid,
    input  logic          wr_bit,
    input  logic          rd_req,
    output logic          rd_bit
);
    typedef struct packed {
        rd_state_e     st;
        logic [2:0]    bcnt;
        logic [7:0]    shf;
        logic [7:0]    crc;
        logic [7:0]    lo;
        logic [7:0]    hi;
        logic [AW-1:0] addr;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic       mem_bit;
    logic       crc_bit_in;
    logic [7:0] crc_stepped;
    logic [7:0] byte_nx;
    logic       in_write_phase;
    logic       start_oob;

    eprom_store #(
        .DEPTH (DEPTH),
        .BW    (8)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .rd_addr   (r_q.addr),
        .rd_sel    (r_q.bcnt),
        .rd_out    (mem_bit)
    );

    assign in_write_phase = (r_q.st == ST_CMD) || (r_q.st == ST_ADDR_LO)
                         || (r_q.st == ST_ADDR_HI);
    assign crc_bit_in     = in_write_phase ? wr_bit : mem_bit;
    assign byte_nx        = {wr_bit, r_q.shf[7:1]};
    assign start_oob      = ({r_q.hi, r_q.lo} >= 16'(DEPTH));

    eprom_bitcrc #(
        .W    (8),
        .POLY (CRC_POLY_REFL)
    ) u_crc (
        .crc_in  (r_q.crc),
        .bit_in  (crc_bit_in),
        .crc_out (crc_stepped)
    );

    // Output bit selection
    always_comb begin
        case (r_q.st)
            ST_HDR_CRC:  rd_bit = r_q.crc[0];
            ST_DATA:     rd_bit = mem_bit;
            ST_DATA_CRC: rd_bit = r_q.crc[0];
            default:     rd_bit = 1'b1;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d = r_q;
        if (bus_rst) begin
            r_d.st   = ST_CMD;
            r_d.bcnt = '0;
            r_d.shf  = '0;
            r_d.crc  = '0;
        end else if (wr_valid && in_write_phase) begin
            r_d.shf  = byte_nx;
            r_d.crc  = crc_stepped;
            r_d.bcnt = r_q.bcnt + 3'd1;
            if (r_q.bcnt == 3'd7) begin
                case (r_q.st)
                    ST_CMD: begin
                        r_d.st = (byte_nx == CMD_READ) ? ST_ADDR_LO : ST_IDLE;
                    end
                    ST_ADDR_LO: begin
                        r_d.lo = byte_nx;
                        r_d.st = ST_ADDR_HI;
                    end
                    default: begin
                        r_d.hi = byte_nx;
                        r_d.st = ST_HDR_CRC;
                    end
                endcase
            end
        end else if (rd_req) begin
            case (r_q.st)
                ST_HDR_CRC: begin
                    r_d.crc  = r_q.crc >> 1;
                    r_d.bcnt = r_q.bcnt + 3'd1;
                    if (r_q.bcnt == 3'd7) begin
                        r_d.crc  = '0;
                        r_d.addr = r_q.lo[AW-1:0];
                        r_d.st   = start_oob ? ST_DATA_CRC : ST_DATA;
                    end
                end
                ST_DATA: begin
                    r_d.crc  = crc_stepped;
                    r_d.bcnt = r_q.bcnt + 3'd1;
                    if (r_q.bcnt == 3'd7) begin
                        if (r_q.addr == AW'(DEPTH - 1)) begin
                            r_d.st = ST_DATA_CRC;
                        end else begin
                            r_d.addr = r_q.addr + AW'(1);
                        end
                    end
                end
                ST_DATA_CRC: begin
                    r_d.crc  = r_q.crc >> 1;
                    r_d.bcnt = r_q.bcnt + 3'd1;
                    if (r_q.bcnt == 3'd7) begin
                        r_d.st = ST_DONE;
                    end
                end
                default: begin
                    r_d = r_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_CMD, bcnt: '0, shf: '0, crc: '0,
                     lo: '0, hi: '0, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/eprom_read_checker.sv
module eprom_read_checker
    import eprom_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst,
    input logic       wr_valid,
    input logic       rd_req,
    input logic       rd_bit,
    input rd_state_e  st,
    input logic [2:0] bcnt
);
    logic wphase;
    assign wphase = (st == ST_CMD) || (st == ST_ADDR_LO) || (st == ST_ADDR_HI);

    // Input assumption: one bit event per slot
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));

    assert_read_in_collect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wphase && rd_req && !bus_rst) |-> rd_bit);

    assert_collect_undisturbed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wphase && rd_req && !wr_valid && !bus_rst) |=> ($stable(st) && $stable(bcnt)));

    assert_done_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> rd_bit);

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !bus_rst) |=> (st == ST_DONE));

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (st == ST_CMD && bcnt == 3'd0));

    assert_idle_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> rd_bit);

    assert_data_ignores_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && wr_valid && !rd_req && !bus_rst) |=> ($stable(st) && $stable(bcnt)));
endmodule

bind eprom_read_engine eprom_read_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .rd_bit   (rd_bit),
    .st       (r_q.st),
    .bcnt     (r_q.bcnt)
);

// File: tb/eprom_read_engine_test.sv
module eprom_read_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [6:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       bus_rst = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_bit = 1'b0;
    logic       rd_req = 1'b0;
    logic       rd_bit;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [128];

    always #10 clk = ~clk;

    eprom_read_engine uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .bus_rst(bus_rst), .wr_valid(wr_valid),
        .wr_bit(wr_bit), .rd_req(rd_req), .rd_bit(rd_bit)
    );

    function automatic logic [7:0] crc_step(logic [7:0] c, logic b);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ 8'h8C;
        return c;
    endfunction

    function automatic logic [7:0] crc_byte(logic [7:0] c, logic [7:0] v);
        for (int i = 0; i < 8; i++) c = crc_step(c, v[i]);
        return c;
    endfunction

    function automatic logic [7:0] data_crc(int start);
        logic [7:0] c = 8'h00;
        for (int a = start; a < 128; a++) c = crc_byte(c, model[a]);
        return c;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put_bit(logic b);
        @(negedge clk);
        wr_valid = 1'b1; wr_bit = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic put_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) put_bit(v[i]);
    endtask

    task automatic get_bit(output logic b);
        @(negedge clk);
        b = rd_bit; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    task automatic pulse_rst();
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic send_header(logic [15:0] adr, output logic [7:0] hcrc);
        put_byte(8'hF0);
        put_byte(adr[7:0]);
        put_byte(adr[15:8]);
        hcrc = crc_byte(crc_byte(crc_byte(8'h00, 8'hF0), adr[7:0]), adr[15:8]);
    endtask

    // Full read transaction, then ones, then bus reset
    task automatic full_read(logic [15:0] adr);
        logic [7:0] exp_h, v;
        send_header(adr, exp_h);
        get_byte(v);
        check("R3 header crc", v, exp_h);
        if (adr < 16'd128) begin
            for (int a = adr; a < 128; a++) begin
                get_byte(v);
                check(a == 127 ? "R1 last byte" : "R4 data byte", v, model[a]);
            end
            get_byte(v);
            check("R5 data crc", v, data_crc(adr));
        end else begin
            get_byte(v);
            check("R9 empty data crc", v, 8'h00);
        end
        get_byte(v);
        check("R6 ones after crc", v, 8'hFF);
        get_byte(v);
        check("R6 ones after crc", v, 8'hFF);
        pulse_rst();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, h;
        logic b;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset idle line", {7'd0, rd_bit}, 8'h01);

        // Preload; byte 127 and some others left erased
        for (int i = 0; i < 127; i++) begin
            if (($urandom % 4) != 0) begin
                @(negedge clk);
                load_en = 1'b1; load_addr = 7'(i); load_data = 8'($urandom);
                model[i] = load_data;
                @(negedge clk);
                load_en = 1'b0;
            end
        end

        full_read(16'd120);
        full_read(16'd0);
        full_read(16'd127);
        for (int k = 0; k < 5; k++) full_read(16'(96 + ($urandom % 32)));

        // R7: abort mid-data, restart
        send_header(16'd5, h);
        get_byte(v);
        check("R3 header crc", v, h);
        for (int k = 0; k < 3; k++) begin
            get_byte(v);
            check("R4 data byte", v, model[5 + k]);
        end
        pulse_rst();
        get_byte(v);
        check("R7 read after abort", v, 8'hFF);
        full_read(16'd123);

        // R7: abort mid-opcode discards partial bits
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        pulse_rst();
        full_read(16'd126);

        // R8: bad opcode
        put_byte(8'h0F);
        get_byte(v);
        check("R8 bad opcode ones", v, 8'hFF);
        put_byte(8'hF0);
        get_byte(v);
        check("R8 writes ignored", v, 8'hFF);
        pulse_rst();

        // R9: out-of-range starts
        full_read(16'h0180);
        full_read(16'd128);

        // R10: writes during data ignored
        send_header(16'd118, h);
        get_byte(v);
        check("R3 header crc", v, h);
        get_byte(v);
        check("R4 data byte", v, model[118]);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        for (int a = 119; a < 128; a++) begin
            get_byte(v);
            check("R10 data after writes", v, model[a]);
        end
        get_byte(v);
        check("R10 crc after writes", v, data_crc(118));
        pulse_rst();

        // R2: read slots during address collection
        put_byte(8'hF0);
        put_bit(1'b0); put_bit(1'b1);
        get_bit(b);
        check("R2 read in collect", {7'd0, b}, 8'h01);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        put_byte(8'h00);
        get_byte(v);
        check("R2 header crc intact", v, crc_byte(crc_byte(crc_byte(8'h00, 8'hF0), 8'h7E), 8'h00));
        for (int a = 126; a < 128; a++) begin
            get_byte(v);
            check("R2 data", v, model[a]);
        end
        pulse_rst();

        // R11: reset with same-cycle write bit
        @(negedge clk);
        bus_rst = 1'b1; wr_valid = 1'b1; wr_bit = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0; wr_valid = 1'b0;
        send_header(16'd124, h);
        get_byte(v);
        check("R11 header crc after priority", v, h);
        pulse_rst();

        // R1: reload and erase by rst_n
        @(negedge clk);
        load_en = 1'b1; load_addr = 7'd127; load_data = 8'h5A; model[127] = 8'h5A;
        @(negedge clk);
        load_en = 1'b0;
        full_read(16'd127);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        full_read(16'd125);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule